// File: doc/BRIEF.md
# Priority Crossbar Pin Allocator

This block sits between a set of on-chip digital peripherals and 32 general-purpose pins arranged as four 8-bit ports. A group-enable register chooses which peripheral groups take part. Each enabled group is packed onto the next free run of consecutive pins. Packing starts at pin 0 (port 0 bit 0) and climbs through the ports in a fixed priority order. A group's pin position therefore depends on which higher-priority groups are also enabled. Every pin that no group claims becomes plain GPIO, driven by its own data latch and direction latch.

Peripheral outputs and output enables are steered onto their pins. Pin input values are steered back to the owning peripheral slots. A peripheral slot with no pin sees a constant idle level. The port read path always returns the raw pin value, whatever the pin is used for. A global crossbar switch forces every pin to GPIO. An overflow flag reports that an enabled group found too few free pins left for the whole group.

Top module: `pxb_crossbar`

## Requirements
- R1: Enabled groups are placed in priority order, group 0 first, each on the next consecutive free pins starting at pin 0. Pin p is port p/8, bit p%8. A group that is not enabled uses no pins.
- R2: Group g (0..10) has 2,4,2,2,6,2,4,8,1,1,1 pins. Peripheral slots are numbered group by group, in the same order. Slot k of a placed group with first pin b maps to pin b+k.
- R3: A group is placed only when all of its pins fit within pins 0..31. Otherwise it takes no pins and `ovf` is 1. Later groups are still tried. `ovf` is 0 whenever every enabled group was placed.
- R4: A pin that no placed group owns drives `pin_out` from its GPIO data latch and `pin_oe` from its GPIO direction latch.
- R5: A pin owned by a placed group drives `pin_out` and `pin_oe` from the owning slot's `periph_out` and `periph_oe`.
- R6: A slot of a placed group receives its pin's `pin_in`. Any other slot receives its idle level. The idle level is 1 for slots 1, 6, 7, 9, 20 and 21 and 0 for all others.
- R7: `port_rd` equals `pin_in` at all times, for GPIO pins and peripheral pins alike.
- R8: While the registered crossbar switch is 0, all pins are GPIO, all slots read their idle level and `ovf` is 0.
- R9: The group enables and the crossbar switch load from `cfg_grp_en`/`cfg_xbar_en` at the clock edge where `cfg_we` is 1. Until that edge, the outputs follow the old setting. After reset the enables, the switch and both GPIO latches are 0.
- R10: The GPIO data and direction latches load from `gpio_dat`/`gpio_dir` at the clock edge where `gpio_we` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load group enables and crossbar switch |
| cfg_xbar_en | input | 1 | Crossbar switch value |
| cfg_grp_en | input | 11 | Group enable value, bit g for group g |
| gpio_we | input | 1 | Load GPIO data and direction latches |
| gpio_dat | input | 32 | GPIO data latch value |
| gpio_dir | input | 32 | GPIO direction latch value (1 = drive) |
| pin_in | input | 32 | Sensed pin levels |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |
| port_rd | output | 32 | Port read data |
| periph_out | input | 33 | Peripheral slot output values |
| periph_oe | input | 33 | Peripheral slot output enables |
| periph_in | output | 33 | Values returned to peripheral slots |
| ovf | output | 1 | A enabled group did not fit |

## Verification
The register paths take one edge. A change on `cfg_we` or `gpio_we` shows on the outputs just after the next rising edge. The routing from `pin_in`, `periph_out` and `periph_oe` is purely combinational. So the bench drives every input at a falling edge and checks at two points. It checks once at that same falling edge, before any register moves, against the old register contents. It checks again one falling edge later, against the new contents. The bench's model registers follow the same single-edge rule.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  localparam int NGRP = 11;
  // pin count per group, index 0 is the highest priority
  localparam int GRP_PINS [NGRP] = '{2, 4, 2, 2, 6, 2, 4, 8, 1, 1, 1};

  // first slot number of group g
  function automatic int slot_off(input int g);
    int s;
    s = 0;
    for (int i = 0; i < g; i++) s += GRP_PINS[i];
    return s;
  endfunction

  localparam int NSLOT = slot_off(NGRP);

  // does group g fit when the next free pin is cursor
  function automatic logic grp_fits(input int cursor, input int g, input int npin);
    return (cursor + GRP_PINS[g]) <= npin;
  endfunction

  // idle level seen by slot k of group g when it owns no pin
  function automatic logic idle_level(input int g, input int k);
    case (g)
      0, 3:    return k == 1;   // serial receive lines idle high
      2:       return 1'b1;     // two-wire bus lines idle high
      6:       return k >= 2;   // active-low interrupt inputs
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pxb_alloc.sv
module pxb_alloc
  import pxb_pkg::*;
#(
  parameter int NPIN = 32,
  localparam int AW = $clog2(NPIN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xbar_en,
  input  logic [NGRP-1:0] grp_en,
  output logic [NGRP-1:0] grp_on,
  output logic [AW-1:0]   grp_base [NGRP],
  output logic [AW-1:0]   used_pins,
  output logic            ovf
);
  int cur;

  always_comb begin
    cur = 0;
    ovf = 1'b0;
    for (int g = 0; g < NGRP; g++) begin
      grp_on[g]   = 1'b0;
      grp_base[g] = '0;
      if (xbar_en && grp_en[g]) begin
        if (grp_fits(cur, g, NPIN)) begin
          grp_on[g]   = 1'b1;
          grp_base[g] = AW'(cur);
          cur         = cur + GRP_PINS[g];
        end else begin
          ovf = 1'b1;
        end
      end
    end
    used_pins = AW'(cur);
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    AST_PLACED_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      grp_on[g] |-> (int'(grp_base[g]) + GRP_PINS[g] <= NPIN)) else $error("group overruns pins"); // R3
  end
endmodule

// File: rtl/pxb_route.sv
module pxb_route
  import pxb_pkg::*;
#(
  parameter int NPIN = 32,
  localparam int AW = $clog2(NPIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NGRP-1:0]  grp_on,
  input  logic [AW-1:0]    grp_base [NGRP],
  input  logic [NPIN-1:0]  gpio_q,
  input  logic [NPIN-1:0]  dir_q,
  input  logic [NPIN-1:0]  pin_in,
  input  logic [NSLOT-1:0] periph_out,
  input  logic [NSLOT-1:0] periph_oe,
  output logic [NPIN-1:0]  pin_out,
  output logic [NPIN-1:0]  pin_oe,
  output logic [NPIN-1:0]  pin_own,
  output logic [NSLOT-1:0] periph_in
);
  // pin side: find the owning group, if any
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [NGRP-1:0] hit;
    int              slot;

    always_comb begin
      hit  = '0;
      slot = 0;
      for (int g = 0; g < NGRP; g++) begin
        if (grp_on[g] && p >= int'(grp_base[g]) && p < int'(grp_base[g]) + GRP_PINS[g]) begin
          hit[g] = 1'b1;
          slot   = slot_off(g) + p - int'(grp_base[g]);
        end
      end
    end

    assign pin_own[p] = |hit;
    assign pin_out[p] = pin_own[p] ? periph_out[slot] : gpio_q[p];
    assign pin_oe[p]  = pin_own[p] ? periph_oe[slot]  : dir_q[p];

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit)) else $error("pin claimed twice"); // R1
  end

  // slot side: return the pin value or the idle level
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    for (genvar k = 0; k < GRP_PINS[g]; k++) begin : g_slot
      localparam int S = slot_off(g) + k;
      int idx;
      always_comb begin
        idx = int'(grp_base[g]) + k;
        if (idx >= NPIN) idx = NPIN - 1;
      end
      assign periph_in[S] = grp_on[g] ? pin_in[idx] : idle_level(g, k);
    end
  end
endmodule

// File: rtl/pxb_crossbar.sv
module pxb_crossbar
  import pxb_pkg::*;
#(
  parameter int NPORT  = 4,
  parameter int PORT_W = 8,
  localparam int NPIN  = NPORT * PORT_W,
  localparam int AW    = $clog2(NPIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_xbar_en,
  input  logic [NGRP-1:0]  cfg_grp_en,
  input  logic             gpio_we,
  input  logic [NPIN-1:0]  gpio_dat,
  input  logic [NPIN-1:0]  gpio_dir,
  input  logic [NPIN-1:0]  pin_in,
  output logic [NPIN-1:0]  pin_out,
  output logic [NPIN-1:0]  pin_oe,
  output logic [NPIN-1:0]  port_rd,
  input  logic [NSLOT-1:0] periph_out,
  input  logic [NSLOT-1:0] periph_oe,
  output logic [NSLOT-1:0] periph_in,
  output logic             ovf
);
  logic            xbar_q;
  logic [NGRP-1:0] en_q;
  logic [NPIN-1:0] gpio_q, dir_q;
  logic [NGRP-1:0] grp_on;
  logic [AW-1:0]   grp_base [NGRP];
  logic [AW-1:0]   used_pins;
  logic [NPIN-1:0] pin_own;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xbar_q <= 1'b0;
      en_q   <= '0;
    end else if (cfg_we) begin
      xbar_q <= cfg_xbar_en;
      en_q   <= cfg_grp_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpio_q <= '0;
      dir_q  <= '0;
    end else if (gpio_we) begin
      gpio_q <= gpio_dat;
      dir_q  <= gpio_dir;
    end
  end

  pxb_alloc #(.NPIN(NPIN)) u_alloc (
    .clk(clk), .rst_n(rst_n), .xbar_en(xbar_q), .grp_en(en_q),
    .grp_on(grp_on), .grp_base(grp_base), .used_pins(used_pins), .ovf(ovf)
  );

  pxb_route #(.NPIN(NPIN)) u_route (
    .clk(clk), .rst_n(rst_n), .grp_on(grp_on), .grp_base(grp_base),
    .gpio_q(gpio_q), .dir_q(dir_q), .pin_in(pin_in),
    .periph_out(periph_out), .periph_oe(periph_oe),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_own(pin_own), .periph_in(periph_in)
  );

  assign port_rd = pin_in;

  AST_CFG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (en_q == $past(cfg_grp_en)) && (xbar_q == $past(cfg_xbar_en))) else $error("cfg load"); // R9
  AST_OWN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pin_own) == int'(used_pins)) else $error("owned pin count"); // R1
  AST_XBAR_OFF_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
    !xbar_q |-> (pin_out == gpio_q) && (pin_oe == dir_q) && !ovf) else $error("switch off"); // R8
endmodule

// File: tb/pxb_crossbar_tb.sv
module pxb_crossbar_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 11;
  localparam int NP = 32;
  localparam int NS = 33;
  localparam int B_CNT [NG] = '{2, 4, 2, 2, 6, 2, 4, 8, 1, 1, 1};
  localparam logic [NS-1:0] IDLE_HI = 33'h0_0030_02C2; // slots 1,6,7,9,20,21

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_xbar_en = 0, gpio_we = 0;
  logic [NG-1:0] cfg_grp_en = '0;
  logic [NP-1:0] gpio_dat = '0, gpio_dir = '0, pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, port_rd;
  logic [NS-1:0] periph_out = '0, periph_oe = '0, periph_in;
  logic ovf;

  // model registers
  logic m_xb = 0;
  logic [NG-1:0] m_en = '0;
  logic [NP-1:0] m_gd = '0, m_gr = '0;

  int vectors = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pxb_crossbar u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_xbar_en(cfg_xbar_en),
    .cfg_grp_en(cfg_grp_en), .gpio_we(gpio_we), .gpio_dat(gpio_dat), .gpio_dir(gpio_dir),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .port_rd(port_rd),
    .periph_out(periph_out), .periph_oe(periph_oe), .periph_in(periph_in), .ovf(ovf)
  );

  logic [NP-1:0] e_out, e_oe;
  logic [NS-1:0] e_in;
  logic e_ovf;

  task automatic model();
    int owner [NP];
    int nxt, slot;
    for (int p = 0; p < NP; p++) owner[p] = -1;
    nxt = 0; slot = 0; e_ovf = 0;
    for (int g = 0; g < NG; g++) begin
      if (m_xb && m_en[g]) begin
        if (nxt + B_CNT[g] <= NP) begin
          for (int k = 0; k < B_CNT[g]; k++) owner[nxt + k] = slot + k;
          nxt += B_CNT[g];
        end else e_ovf = 1;
      end
      slot += B_CNT[g];
    end
    e_in = IDLE_HI;
    for (int p = 0; p < NP; p++) begin
      if (owner[p] >= 0) begin
        e_out[p] = periph_out[owner[p]];
        e_oe[p]  = periph_oe[owner[p]];
        e_in[owner[p]] = pin_in[p];
      end else begin
        e_out[p] = m_gd[p];
        e_oe[p]  = m_gr[p];
      end
    end
  endtask

  task automatic check(input string tag);
    model();
    vectors++;
    if (pin_out !== e_out || pin_oe !== e_oe || periph_in !== e_in || ovf !== e_ovf || port_rd !== pin_in) begin
      fails++;
      $display("FAIL %s: out=%h oe=%h in=%h ovf=%b rd=%h exp out=%h oe=%h in=%h ovf=%b rd=%h",
               tag, pin_out, pin_oe, periph_in, ovf, port_rd, e_out, e_oe, e_in, e_ovf, pin_in);
    end
  endtask

  // at a falling edge: set config, wait one edge, check
  task automatic set_cfg(input logic xb, input logic [NG-1:0] en, input string tag);
    cfg_we = 1; cfg_xbar_en = xb; cfg_grp_en = en;
    @(negedge clk);
    cfg_we = 0; m_xb = xb; m_en = en;
    check(tag);
  endtask

  task automatic expect_pin(input int p, input logic v, input string tag);
    vectors++;
    if (pin_out[p] !== v) begin
      fails++;
      $display("FAIL %s: pin_out[%0d]=%b exp %b", tag, p, pin_out[p], v);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    #(CLK_PERIOD*3);
    @(negedge clk);
    check("R9 during reset");
    rst_n = 1;
    @(negedge clk);
    check("R9 reset state");

    periph_out = '1; periph_oe = '1; pin_in = 32'hA5C3_0F96;
    // group 3 alone lands on pins 0,1
    set_cfg(1, 11'b000_0000_1000, "R1 single group at pin 0");
    expect_pin(1, 1'b1, "R1 pin1 owned");
    expect_pin(2, 1'b0, "R4 pin2 gpio");
    // groups 4 and 10: pins 0..5 then pin 6
    set_cfg(1, 11'b100_0001_0000, "R1 R2 packed order");
    // all enabled: last group dropped
    set_cfg(1, '1, "R3 overflow all enabled");
    // switch off with all enables
    set_cfg(0, '1, "R8 switch off");
    // GPIO latch write
    gpio_we = 1; gpio_dat = 32'h1234_5678; gpio_dir = 32'hF0F0_0FF0;
    @(negedge clk);
    gpio_we = 0; m_gd = gpio_dat; m_gr = gpio_dir;
    check("R10 gpio latches");
    // R9 old setting holds before the edge
    cfg_we = 1; cfg_xbar_en = 1; cfg_grp_en = 11'b000_0000_0001;
    #1 check("R9 before edge");
    @(negedge clk);
    cfg_we = 0; m_xb = 1; m_en = 11'b000_0000_0001;
    check("R9 after edge");

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      cfg_we = $urandom_range(0, 1);
      cfg_xbar_en = ($urandom_range(0, 7) != 0);
      cfg_grp_en = ($urandom_range(0, 5) == 0) ? '1 : NG'($urandom);
      gpio_we = $urandom_range(0, 1);
      gpio_dat = $urandom; gpio_dir = $urandom;
      pin_in = $urandom;
      periph_out = {1'($urandom), 32'($urandom)};
      periph_oe  = {1'($urandom), 32'($urandom)};
      #1 check("R9 R7 R6 pre-edge");
      @(negedge clk);
      if (cfg_we) begin m_xb = cfg_xbar_en; m_en = cfg_grp_en; end
      if (gpio_we) begin m_gd = gpio_dat; m_gr = gpio_dir; end
      cfg_we = 0; gpio_we = 0;
      check("R1 R2 R3 R4 R5 R6 R7 R8 R10 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule